// File: doc/BRIEF.md
# Idle and Power-Down Controller

This block sequences the low-power modes of a small 8-bit microcontroller. Software writes an idle request bit and a power-down request bit. The block then stops the CPU clock alone (idle) or halts the oscillator and everything it drives (power-down). It also qualifies the external reset pin, derives the internal clock through a divide-by-two stage, and produces a gated CPU clock and a gated peripheral clock.

Each mode has its own exit rule. Idle ends on an enabled interrupt or on a reset. Power-down ends only on a qualified hardware reset. While the reset pin is high, the oscillator enable is forced on so that the qualifier has a running clock to count with. When a reset ends idle, the CPU resumes for a short time before the internal reset takes over. During that gap the block raises a RAM-access inhibit so that internal RAM cannot be written. Port-pin access is left alone.

The CPU core, the peripherals, the analog oscillator and the RAM are outside this block. They appear here only as enable and strobe ports. An active-low power-on reset initialises the sequencer.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset, both mode flags are 0, `int_rst` and `ram_inhibit` are 0, `osc_en` is 1, and both clock enables are 1.
- R2: A write strobe with `wr_idl`=1 and `wr_pd`=0, issued in normal run, sets `idl_flag` on the next oscillator edge. Within four oscillator periods it drops `cpu_clk_en`, and `cpu_clk` then shows no rising edge. `per_clk_en` stays 1.
- R3: In idle, `irq_pend`=1 returns the block to run on the next oscillator edge and clears `idl_flag`. In run, `irq_pend` has no effect on the flags.
- R4: A write with both bits set enters power-down only, so `pd_flag`=1 and `idl_flag`=0. Writes issued while idle or in power-down leave both flags unchanged.
- R5: In power-down, `osc_en` is 0 while `rst_pin` is low. Both clock enables fall, and neither gated clock toggles. `irq_pend` does not change `pd_flag`.
- R6: `int_rst` rises after the 24th consecutive oscillator rising edge at which `rst_pin` is sampled high, which is two machine cycles of 12 periods each. A shorter high pulse never asserts it and restarts the count. `int_rst` holds while the pin stays high and falls on the first edge at which the pin is sampled low.
- R7: Power-down is left only through `int_rst`. `osc_en` returns to 1 as soon as `rst_pin` goes high, and `pd_flag` clears on the edge after `int_rst` rises.
- R8: When `rst_pin` is sampled high in idle, `idl_flag` clears and `ram_inhibit` rises on that edge, and the CPU clock enable returns. `ram_inhibit` stays 1 until the edge after `int_rst` rises, or until the pin is sampled low first.
- R9: When enabled, each gated clock runs at half the oscillator rate, giving exactly 10 rising edges over 20 oscillator periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Active-low power-on reset |
| rst_pin | input | 1 | External hardware reset pin, active high |
| sfr_wr | input | 1 | Strobe for a software write of the mode bits |
| wr_idl | input | 1 | Idle request bit carried by the write |
| wr_pd | input | 1 | Power-down request bit carried by the write |
| irq_pend | input | 1 | An enabled interrupt is pending |
| cpu_clk | output | 1 | Gated divided clock for the CPU |
| per_clk | output | 1 | Gated divided clock for RAM, timers, serial port and interrupt logic |
| cpu_clk_en | output | 1 | Current enable of the CPU clock gate |
| per_clk_en | output | 1 | Current enable of the peripheral clock gate |
| osc_en | output | 1 | Oscillator run enable |
| int_rst | output | 1 | Qualified internal reset |
| ram_inhibit | output | 1 | Blocks internal RAM access in the idle-to-reset gap |
| idl_flag | output | 1 | Idle request bit, as read back by software |
| pd_flag | output | 1 | Power-down request bit, as read back by software |

## Verification
A table of one-cycle operations drives idle entry, interrupt exit, empty writes, writes issued inside idle and interrupts issued in run. This separates the mode transitions from writes and interrupts that must be ignored. Directed sequences then count gated-clock edges in run, idle and power-down, which shows which clock domain each mode stops.

Reset-pin pulses of 23 and 24 oscillator periods bracket the qualification threshold. A pulse of 23 periods must never assert `int_rst`, and one of 24 must. A reset raised during idle exercises the RAM-inhibit window and shows where it starts and ends. A reset raised in power-down shows the oscillator restarting and power-down being left.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   // Sequencer states; WAKE is the idle-to-reset gap with RAM inhibited
   typedef enum logic [1:0] {
      PM_RUN   = 2'd0,
      PM_IDLE  = 2'd1,
      PM_PDOWN = 2'd2,
      PM_WAKE  = 2'd3
   } pm_state_e;

   localparam int DOM_CPU = 0;
   localparam int DOM_PER = 1;
   localparam int NUM_DOM = 2;
endpackage

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual #(
   parameter int SYNC_STAGES = 0,
   parameter int QUAL_CNT    = 24
) (
   input  logic osc_clk,
   input  logic por_n,
   input  logic rst_pin,
   output logic pin_s,
   output logic int_rst
);
   localparam int CW = $clog2(QUAL_CNT + 1);
   localparam logic [CW-1:0] CNT_MAX  = CW'(QUAL_CNT);
   localparam logic [CW-1:0] CNT_LAST = CW'(QUAL_CNT - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign pin_s = rst_pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge osc_clk or negedge por_n) begin
            if (!por_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-2:0], rst_pin};
         end
         assign pin_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   // Counts consecutive high samples; saturates so the reset holds
   always_ff @(posedge osc_clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q   <= '0;
         int_rst <= 1'b0;
      end else if (!pin_s) begin
         cnt_q   <= '0;
         int_rst <= 1'b0;
      end else begin
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
         if (cnt_q == CNT_LAST) int_rst <= 1'b1;
      end
   end
endmodule

// File: rtl/pwr_clk_div.sv
module pwr_clk_div (
   input  logic osc_clk,
   input  logic por_n,
   input  logic run,
   output logic div_clk
);
   // Stops only in the low phase so downstream gates can close cleanly
   always_ff @(posedge osc_clk or negedge por_n) begin
      if (!por_n)               div_clk <= 1'b0;
      else if (run || div_clk)  div_clk <= ~div_clk;
   end
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate (
   input  logic osc_clk,
   input  logic por_n,
   input  logic div_clk,
   input  logic en_d,
   output logic en_q,
   output logic gclk
);
   // Enable moves on the falling oscillator edge while the divided clock is low
   always_ff @(negedge osc_clk or negedge por_n) begin
      if (!por_n)        en_q <= 1'b1;
      else if (!div_clk) en_q <= en_d;
   end

   assign gclk = div_clk & en_q;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
(
   input  logic      osc_clk,
   input  logic      por_n,
   input  logic      pin_s,
   input  logic      int_rst,
   input  logic      sfr_wr,
   input  logic      wr_idl,
   input  logic      wr_pd,
   input  logic      irq_pend,
   output pm_state_e state_q
);
   pm_state_e state_d;

   always_comb begin
      state_d = state_q;
      if (int_rst) begin
         state_d = PM_RUN;
      end else begin
         case (state_q)
            PM_RUN: begin
               if (sfr_wr && wr_pd)       state_d = PM_PDOWN;
               else if (sfr_wr && wr_idl) state_d = PM_IDLE;
            end
            PM_IDLE: begin
               if (pin_s)         state_d = PM_WAKE;
               else if (irq_pend) state_d = PM_RUN;
            end
            PM_WAKE: begin
               if (!pin_s) state_d = PM_RUN;
            end
            PM_PDOWN: state_d = PM_PDOWN;
            default:  state_d = PM_RUN;
         endcase
      end
   end

   always_ff @(posedge osc_clk or negedge por_n) begin
      if (!por_n) state_q <= PM_RUN;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int OSC_PER_MC  = 12,
   parameter int RST_MC      = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic osc_clk,
   input  logic por_n,
   input  logic rst_pin,
   input  logic sfr_wr,
   input  logic wr_idl,
   input  logic wr_pd,
   input  logic irq_pend,
   output logic cpu_clk,
   output logic per_clk,
   output logic cpu_clk_en,
   output logic per_clk_en,
   output logic osc_en,
   output logic int_rst,
   output logic ram_inhibit,
   output logic idl_flag,
   output logic pd_flag
);
   localparam int QUAL_CNT = OSC_PER_MC * RST_MC;

   generate
      if ((OSC_PER_MC % 2) != 0 || OSC_PER_MC < 2) begin : g_bad_mc
         $error("OSC_PER_MC must be an even value of at least 2");
      end
      if (RST_MC < 1) begin : g_bad_rst
         $error("RST_MC must be at least 1");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   pm_state_e          state_q;
   logic               pin_s;
   logic               div_clk;
   logic [NUM_DOM-1:0] dom_en_d;
   logic [NUM_DOM-1:0] dom_en_q;
   logic [NUM_DOM-1:0] dom_clk;

   pwr_rst_qual #(
      .SYNC_STAGES(SYNC_STAGES),
      .QUAL_CNT   (QUAL_CNT)
   ) qual_i (
      .osc_clk(osc_clk),
      .por_n  (por_n),
      .rst_pin(rst_pin),
      .pin_s  (pin_s),
      .int_rst(int_rst)
   );

   pwr_mode_fsm fsm_i (
      .osc_clk (osc_clk),
      .por_n   (por_n),
      .pin_s   (pin_s),
      .int_rst (int_rst),
      .sfr_wr  (sfr_wr),
      .wr_idl  (wr_idl),
      .wr_pd   (wr_pd),
      .irq_pend(irq_pend),
      .state_q (state_q)
   );

   // The pin restarts the oscillator at once so the qualifier can count
   assign osc_en = (state_q != PM_PDOWN) || rst_pin;

   pwr_clk_div div_i (
      .osc_clk(osc_clk),
      .por_n  (por_n),
      .run    (osc_en),
      .div_clk(div_clk)
   );

   assign dom_en_d[DOM_CPU] = (state_q == PM_RUN) || (state_q == PM_WAKE);
   assign dom_en_d[DOM_PER] = (state_q != PM_PDOWN);

   generate
      for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
         pwr_clk_gate gate_i (
            .osc_clk(osc_clk),
            .por_n  (por_n),
            .div_clk(div_clk),
            .en_d   (dom_en_d[d]),
            .en_q   (dom_en_q[d]),
            .gclk   (dom_clk[d])
         );
      end
   endgenerate

   assign cpu_clk     = dom_clk[DOM_CPU];
   assign per_clk     = dom_clk[DOM_PER];
   assign cpu_clk_en  = dom_en_q[DOM_CPU];
   assign per_clk_en  = dom_en_q[DOM_PER];
   assign ram_inhibit = (state_q == PM_WAKE);
   assign idl_flag    = (state_q == PM_IDLE);
   assign pd_flag     = (state_q == PM_PDOWN);
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
   input logic osc_clk,
   input logic por_n,
   input logic rst_pin,
   input logic irq_pend,
   input logic int_rst,
   input logic idl_flag,
   input logic pd_flag,
   input logic ram_inhibit
);
   assert_irq_ends_idle_R3: assert property (@(posedge osc_clk) disable iff (!por_n)
      (idl_flag && irq_pend && !rst_pin && !int_rst) |=> (!idl_flag && !ram_inhibit));

   assert_modes_exclusive_R4: assert property (@(posedge osc_clk) disable iff (!por_n)
      !(idl_flag && pd_flag));

   assert_rst_needs_pin_R6: assert property (@(posedge osc_clk) disable iff (!por_n)
      $rose(int_rst) |-> $past(rst_pin));

   assert_rst_release_R6: assert property (@(posedge osc_clk) disable iff (!por_n)
      (int_rst && !rst_pin) |=> !int_rst);

   assert_pd_held_R7: assert property (@(posedge osc_clk) disable iff (!por_n)
      (pd_flag && !int_rst) |=> pd_flag);

   assert_inhibit_ends_R8: assert property (@(posedge osc_clk) disable iff (!por_n)
      (ram_inhibit && int_rst) |=> !ram_inhibit);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk chk_i (
   .osc_clk    (osc_clk),
   .por_n      (por_n),
   .rst_pin    (rst_pin),
   .irq_pend   (irq_pend),
   .int_rst    (int_rst),
   .idl_flag   (idl_flag),
   .pd_flag    (pd_flag),
   .ram_inhibit(ram_inhibit)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 7;
   // {sfr_wr, wr_idl, wr_pd, irq_pend, exp_idl, exp_pd}
   localparam logic [5:0] VEC [NVEC] = '{
      6'b110_0_10,   // idle entry (R2)
      6'b000_1_00,   // interrupt leaves idle (R3)
      6'b100_0_00,   // empty write
      6'b110_0_10,   // idle entry again (R2)
      6'b101_0_10,   // write inside idle ignored (R4)
      6'b000_1_00,   // interrupt leaves idle (R3)
      6'b000_1_00    // interrupt in run ignored (R3)
   };

   logic osc_clk = 1'b0;
   logic por_n = 1'b0;
   logic rst_pin = 1'b0;
   logic sfr_wr = 1'b0;
   logic wr_idl = 1'b0;
   logic wr_pd = 1'b0;
   logic irq_pend = 1'b0;
   logic cpu_clk, per_clk, cpu_clk_en, per_clk_en, osc_en;
   logic int_rst, ram_inhibit, idl_flag, pd_flag;

   int checks = 0;
   int errors = 0;
   int cpu_edges = 0;
   int per_edges = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
   always @(posedge cpu_clk) cpu_edges++;
   always @(posedge per_clk) per_edges++;

   pwr_mode_ctrl dut_i (
      .osc_clk(osc_clk), .por_n(por_n), .rst_pin(rst_pin),
      .sfr_wr(sfr_wr), .wr_idl(wr_idl), .wr_pd(wr_pd), .irq_pend(irq_pend),
      .cpu_clk(cpu_clk), .per_clk(per_clk), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .osc_en(osc_en), .int_rst(int_rst),
      .ram_inhibit(ram_inhibit), .idl_flag(idl_flag), .pd_flag(pd_flag)
   );

   task automatic step(input int n);
      repeat (n) @(posedge osc_clk);
      #2;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_edges(output int c, output int p);
      int c0, p0;
      c0 = cpu_edges; p0 = per_edges;
      step(20);
      c = cpu_edges - c0; p = per_edges - p0;
   endtask

   task automatic write(input logic i, input logic p);
      sfr_wr = 1'b1; wr_idl = i; wr_pd = p;
      step(1);
      sfr_wr = 1'b0; wr_idl = 1'b0; wr_pd = 1'b0;
   endtask

   initial begin
      int ce, pe;
      step(3);
      por_n = 1'b1;
      step(2);
      // R1 reset state
      chk("R1 idl_flag", idl_flag, 0);
      chk("R1 pd_flag", pd_flag, 0);
      chk("R1 int_rst", int_rst, 0);
      chk("R1 ram_inhibit", ram_inhibit, 0);
      chk("R1 osc_en", osc_en, 1);
      chk("R1 cpu_clk_en", cpu_clk_en, 1);
      chk("R1 per_clk_en", per_clk_en, 1);

      // R9 divided clocks in run
      count_edges(ce, pe);
      chk("R9 cpu edges", ce, 10);
      chk("R9 per edges", pe, 10);

      // table walk: R2 R3 R4
      for (int k = 0; k < NVEC; k++) begin
         sfr_wr = VEC[k][5]; wr_idl = VEC[k][4]; wr_pd = VEC[k][3]; irq_pend = VEC[k][2];
         step(1);
         sfr_wr = 1'b0; wr_idl = 1'b0; wr_pd = 1'b0; irq_pend = 1'b0;
         chk($sformatf("R2/R3/R4 vec%0d idl", k), idl_flag, int'(VEC[k][1]));
         chk($sformatf("R2/R3/R4 vec%0d pd", k), pd_flag, int'(VEC[k][0]));
      end

      // R2 idle clock gating
      write(1'b1, 1'b0);
      step(4);
      chk("R2 cpu_clk_en", cpu_clk_en, 0);
      chk("R2 per_clk_en", per_clk_en, 1);
      count_edges(ce, pe);
      chk("R2 cpu edges idle", ce, 0);
      chk("R9 per edges idle", pe, 10);
      irq_pend = 1'b1; step(1); irq_pend = 1'b0;
      chk("R3 exit idl_flag", idl_flag, 0);
      step(4);
      chk("R3 cpu_clk_en back", cpu_clk_en, 1);

      // R4 power-down priority, R5 power-down behaviour
      write(1'b1, 1'b1);
      chk("R4 pd_flag", pd_flag, 1);
      chk("R4 idl_flag", idl_flag, 0);
      chk("R5 osc_en", osc_en, 0);
      step(4);
      chk("R5 cpu_clk_en", cpu_clk_en, 0);
      chk("R5 per_clk_en", per_clk_en, 0);
      count_edges(ce, pe);
      chk("R5 cpu edges", ce, 0);
      chk("R5 per edges", pe, 0);
      irq_pend = 1'b1; step(2); irq_pend = 1'b0;
      chk("R5 irq ignored", pd_flag, 1);
      write(1'b1, 1'b0);
      chk("R4 write in pd ignored", idl_flag, 0);

      // R7 exit power-down through qualified reset
      rst_pin = 1'b1; #1;
      chk("R7 osc_en on pin", osc_en, 1);
      step(23);
      chk("R6 int_rst at 23", int_rst, 0);
      chk("R7 still pd", pd_flag, 1);
      step(1);
      chk("R6 int_rst at 24", int_rst, 1);
      chk("R7 pd until next edge", pd_flag, 1);
      step(1);
      chk("R7 pd cleared", pd_flag, 0);
      step(5);
      chk("R6 int_rst held", int_rst, 1);
      rst_pin = 1'b0;
      step(1);
      chk("R6 int_rst released", int_rst, 0);
      step(4);
      chk("R7 cpu_clk_en", cpu_clk_en, 1);

      // R6 short pulse then restart of count
      rst_pin = 1'b1; step(23); rst_pin = 1'b0;
      chk("R6 short pulse", int_rst, 0);
      step(1);
      chk("R6 short pulse after", int_rst, 0);
      rst_pin = 1'b1; step(23);
      chk("R6 recount 23", int_rst, 0);
      step(1);
      chk("R6 recount 24", int_rst, 1);
      rst_pin = 1'b0; step(2);

      // R8 reset ends idle
      write(1'b1, 1'b0);
      step(4);
      rst_pin = 1'b1;
      step(1);
      chk("R8 inhibit rises", ram_inhibit, 1);
      chk("R8 idl cleared", idl_flag, 0);
      step(4);
      chk("R8 cpu_clk_en", cpu_clk_en, 1);
      step(19);
      chk("R8 int_rst", int_rst, 1);
      chk("R8 inhibit held", ram_inhibit, 1);
      step(1);
      chk("R8 inhibit released", ram_inhibit, 0);
      rst_pin = 1'b0; step(2);

      // R8 short pin pulse during idle
      write(1'b1, 1'b0);
      rst_pin = 1'b1; step(5);
      chk("R8 short inhibit", ram_inhibit, 1);
      rst_pin = 1'b0; step(1);
      chk("R8 short release", ram_inhibit, 0);
      chk("R8 short no reset", int_rst, 0);
      chk("R8 short back to run", idl_flag, 0);

      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge osc_clk);
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule